// File: doc/BRIEF.md
# Pin Event Detector with Interrupt and DMA Request Outputs

This block watches a bank of general-purpose input pins and turns level and edge events on them into status flags. Each pin owns a 4-bit event code, held in a small set of configuration words on a simple register bus. The code decides which event the pin looks for. It also decides what the event produces: a DMA request that clears itself when the transfer completes, a shared interrupt line, a flag with no other output, or a direct trigger output that follows the pin. Some codes turn the pin off.

Every pin goes through a two-flop synchronizer. Edges are found by comparing the synchronized level with the level one cycle earlier. All flags sit together in one status word. Software clears flags by writing ones to that word. A per-pin DMA completion input clears the flags of DMA-configured pins. The DMA engine and the interrupt controller that use these outputs sit outside the block.

Top module: `pin_event_detector`

## Requirements
- R1: Codes 0, 4 and 15 never set the pin's flag and drive no interrupt, DMA request or trigger for that pin.
- R2: Codes 1, 2 and 3 set the flag on a rising, falling or either edge respectively, and `dma_req_o[n]` is high exactly while pin n has its flag set under one of these codes.
- R3: A high `dma_done_i[n]` clears the flag of pin n when pin n uses code 1, 2 or 3. On a pin with any other code it has no effect.
- R4: Codes 5, 6 and 7 set the flag on a rising, falling or either edge and raise neither `irq_o` nor `dma_req_o`.
- R5: Codes 9, 10 and 11 set the flag on a rising, falling or either edge. `irq_o` is the OR of the flags of all pins whose code is in the range 8 to 12.
- R6: Code 8 sets the flag while the synchronized pin is 0, and code 12 sets it while the pin is 1. If the level is still present, the flag sets again in the same cycle as a clear, so it reads back as still set.
- R7: Code 13 makes `trig_o[n]` equal the synchronized pin level, and code 14 makes it the inverse. These codes never set the flag. `trig_o[n]` is 0 under every other code.
- R8: The status word is at bus address CFG_WORDS (4 by default), with bit n belonging to pin n. Writing 1 to a bit clears that flag. Writing 0 leaves it unchanged.
- R9: The configuration words are at addresses 0 to CFG_WORDS-1 and read back what was written. The code of pin n is at word n/8, bits 4*(n%8)+3 down to 4*(n%8).
- R10: A pin change driven between clock edges shows in its flag after the third following rising edge: two synchronizer stages plus the flag register.
- R11: When an event and a clear (write-one or DMA done) hit the same flag in the same cycle, the flag ends up set.
- R12: After reset all flags and configuration words are 0, and `irq_o`, `dma_req_o` and `trig_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_PINS | Asynchronous pin levels |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Register address for read and write |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for bus_addr_i, combinational |
| irq_o | output | 1 | Shared interrupt line |
| dma_req_o | output | NUM_PINS | Per-pin DMA request |
| dma_done_i | input | NUM_PINS | Per-pin DMA transfer completion |
| trig_o | output | NUM_PINS | Per-pin trigger output |

## Verification
The bench sweeps all sixteen codes through the same rise, clear, fall and DMA-done sequence and computes the expected flags from the code class. A decoder that mixed up rise and fall, let a reserved code through, or routed flag-only pins to the interrupt would show up in the first mismatched word. Level codes are cleared while their level is still present, so a design that let the clear win would read back zero where ones are expected. DMA done is sent to pins of every class, which catches a design that clears flags of non-DMA pins. A clear lands in exactly the cycle an edge is captured, and the flag is sampled at each of the three edges after a pin change, which catches a design with an extra or missing pipeline stage.

// File: rtl/pin_evt_pkg.sv
package pin_evt_pkg;

   localparam int CODE_W = 4;

   typedef struct packed {
      logic on_rise;
      logic on_fall;
      logic on_low;
      logic on_high;
      logic is_dma;
      logic is_irq;
      logic trg_hi;
      logic trg_lo;
   } evt_decode_t;

   function automatic evt_decode_t decode_code(input logic [CODE_W-1:0] c);
      evt_decode_t d;
      d = '0;
      case (c)
         4'd1:  begin d.on_rise = 1'b1; d.is_dma = 1'b1; end
         4'd2:  begin d.on_fall = 1'b1; d.is_dma = 1'b1; end
         4'd3:  begin d.on_rise = 1'b1; d.on_fall = 1'b1; d.is_dma = 1'b1; end
         4'd5:  d.on_rise = 1'b1;
         4'd6:  d.on_fall = 1'b1;
         4'd7:  begin d.on_rise = 1'b1; d.on_fall = 1'b1; end
         4'd8:  begin d.on_low  = 1'b1; d.is_irq = 1'b1; end
         4'd9:  begin d.on_rise = 1'b1; d.is_irq = 1'b1; end
         4'd10: begin d.on_fall = 1'b1; d.is_irq = 1'b1; end
         4'd11: begin d.on_rise = 1'b1; d.on_fall = 1'b1; d.is_irq = 1'b1; end
         4'd12: begin d.on_high = 1'b1; d.is_irq = 1'b1; end
         4'd13: d.trg_hi = 1'b1;
         4'd14: d.trg_lo = 1'b1;
         default: d = '0;
      endcase
      return d;
   endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pin_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("pin_sync: WIDTH must be positive");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= async_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/pin_evt_regs.sv
module pin_evt_regs #(
   parameter int NUM_PINS = 32,
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_i,
   input  logic [ADDR_W-1:0]        addr_i,
   input  logic [DATA_W-1:0]        wdata_i,
   output logic [DATA_W-1:0]        rdata_o,
   input  logic [NUM_PINS-1:0]      status_i,
   output logic [NUM_PINS-1:0]      status_clr_o,
   output logic [NUM_PINS*4-1:0]    codes_o
);

   localparam int PPW       = DATA_W / 4;
   localparam int CFG_WORDS = (NUM_PINS + PPW - 1) / PPW;
   localparam int STAT_ADDR = CFG_WORDS;

   if (DATA_W % 4 != 0) begin : g_bad_dw
      $error("pin_evt_regs: DATA_W must be a multiple of 4");
   end
   if (NUM_PINS > DATA_W) begin : g_bad_np
      $error("pin_evt_regs: NUM_PINS must fit in one status word");
   end
   if ((1 << ADDR_W) <= CFG_WORDS) begin : g_bad_aw
      $error("pin_evt_regs: ADDR_W too small for the register map");
   end

   logic [DATA_W-1:0] cfg_q [CFG_WORDS];
   logic              stat_sel;

   assign stat_sel = (addr_i == ADDR_W'(STAT_ADDR));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int w = 0; w < CFG_WORDS; w++) cfg_q[w] <= '0;
      end else if (wr_i) begin
         for (int w = 0; w < CFG_WORDS; w++) begin
            if (addr_i == ADDR_W'(w)) cfg_q[w] <= wdata_i;
         end
      end
   end

   assign status_clr_o = (wr_i && stat_sel) ? wdata_i[NUM_PINS-1:0] : '0;

   always_comb begin
      rdata_o = '0;
      for (int w = 0; w < CFG_WORDS; w++) begin
         if (addr_i == ADDR_W'(w)) rdata_o = cfg_q[w];
      end
      if (stat_sel) rdata_o = DATA_W'(status_i);
   end

   for (genvar n = 0; n < NUM_PINS; n++) begin : g_code
      localparam int WI = n / PPW;
      localparam int BI = (n % PPW) * 4;
      assign codes_o[n*4 +: 4] = cfg_q[WI][BI +: 4];
   end

endmodule

// File: rtl/pin_evt_cell.sv
module pin_evt_cell
   import pin_evt_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] code_i,
   input  logic              lvl_i,
   input  logic              clr_i,
   input  logic              dma_done_i,
   output logic              flag_o,
   output logic              irq_o,
   output logic              dma_req_o,
   output logic              trig_o
);

   evt_decode_t dec;
   logic        prev_q;
   logic        flag_q;
   logic        rise, fall, set_ev, drop;

   assign dec  = decode_code(code_i);
   assign rise = lvl_i & ~prev_q;
   assign fall = ~lvl_i & prev_q;

   assign set_ev = (dec.on_rise & rise) | (dec.on_fall & fall) |
                   (dec.on_low & ~lvl_i) | (dec.on_high & lvl_i);
   assign drop   = clr_i | (dma_done_i & dec.is_dma);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         prev_q <= lvl_i;
         if (set_ev)    flag_q <= 1'b1;
         else if (drop) flag_q <= 1'b0;
      end
   end

   assign flag_o    = flag_q;
   assign irq_o     = flag_q & dec.is_irq;
   assign dma_req_o = flag_q & dec.is_dma;
   assign trig_o    = (dec.trg_hi & lvl_i) | (dec.trg_lo & ~lvl_i);

   // R11
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_ev |=> flag_q);

   // R8
   w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_ev) |=> !flag_q);

   // R3
   dma_autoclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_done_i && dec.is_dma && !set_ev) |=> !flag_q);

   // R1
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!dec.on_rise && !dec.on_fall && !dec.on_low && !dec.on_high && !flag_q)
      |=> !flag_q);

endmodule

// File: rtl/pin_event_detector.sv
module pin_event_detector
   import pin_evt_pkg::*;
#(
   parameter int NUM_PINS    = 32,
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_i,
   input  logic                bus_wr_i,
   input  logic [ADDR_W-1:0]   bus_addr_i,
   input  logic [DATA_W-1:0]   bus_wdata_i,
   output logic [DATA_W-1:0]   bus_rdata_o,
   output logic                irq_o,
   output logic [NUM_PINS-1:0] dma_req_o,
   input  logic [NUM_PINS-1:0] dma_done_i,
   output logic [NUM_PINS-1:0] trig_o
);

   if (NUM_PINS < 1) begin : g_bad_np
      $error("pin_event_detector: NUM_PINS must be positive");
   end

   logic [NUM_PINS-1:0]        lvl;
   logic [NUM_PINS-1:0]        status;
   logic [NUM_PINS-1:0]        clr;
   logic [NUM_PINS-1:0]        irq_vec;
   logic [NUM_PINS*CODE_W-1:0] codes;

   pin_sync #(
      .WIDTH  (NUM_PINS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (pin_i),
      .sync_o  (lvl)
   );

   pin_evt_regs #(
      .NUM_PINS (NUM_PINS),
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W)
   ) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_i         (bus_wr_i),
      .addr_i       (bus_addr_i),
      .wdata_i      (bus_wdata_i),
      .rdata_o      (bus_rdata_o),
      .status_i     (status),
      .status_clr_o (clr),
      .codes_o      (codes)
   );

   for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
      pin_evt_cell u_cell (
         .clk        (clk),
         .rst_n      (rst_n),
         .code_i     (codes[n*CODE_W +: CODE_W]),
         .lvl_i      (lvl[n]),
         .clr_i      (clr[n]),
         .dma_done_i (dma_done_i[n]),
         .flag_o     (status[n]),
         .irq_o      (irq_vec[n]),
         .dma_req_o  (dma_req_o[n]),
         .trig_o     (trig_o[n])
      );
   end

   assign irq_o = |irq_vec;

   // R5
   irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (status != '0));

   // R2
   dma_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_req_o & ~status) == '0);

endmodule

// File: tb/pin_event_detector_tb.sv
`timescale 1ns/1ps
module pin_event_detector_tb;

   localparam int NP = 32;
   localparam logic [31:0] EVN = 32'h5555_5555;
   localparam logic [2:0]  STAT = 3'd4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] pins = '0;
   logic        wr = 1'b0;
   logic [2:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;
   logic [31:0] dreq;
   logic [31:0] ddone = '0;
   logic [31:0] trig;

   int nchk = 0;
   int nfail = 0;

   always #2.5 clk = ~clk;

   pin_event_detector u_dut (
      .clk(clk), .rst_n(rst_n), .pin_i(pins), .bus_wr_i(wr), .bus_addr_i(addr),
      .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq), .dma_req_o(dreq),
      .dma_done_i(ddone), .trig_o(trig)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      wr = 1'b1; addr = a; wdata = d;
      @(posedge clk);
      @(negedge clk);
      wr = 1'b0; wdata = '0;
      #1;
   endtask

   task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(posedge clk);
      @(negedge clk);
      #1;
   endtask

   function automatic bit is_rise(input int c);
      return c == 1 || c == 3 || c == 5 || c == 7 || c == 9 || c == 11;
   endfunction
   function automatic bit is_fall(input int c);
      return c == 2 || c == 3 || c == 6 || c == 7 || c == 10 || c == 11;
   endfunction

   task automatic check_all(input string tag, input int c, input logic [31:0] exp,
                            input logic [31:0] pin_now);
      logic [31:0] st;
      logic [31:0] texp;
      rd_reg(STAT, st);
      check({tag, " status R2 R4 R5 R6"}, st, exp);
      check({tag, " irq R5"}, {31'd0, irq},
            {31'd0, (c >= 8 && c <= 12 && exp != 0)});
      check({tag, " dma_req R2 R4"}, dreq, (c >= 1 && c <= 3) ? exp : 32'd0);
      texp = (c == 13) ? pin_now : (c == 14) ? ~pin_now : 32'd0;
      check({tag, " trig R7 R1"}, trig, texp);
   endtask

   initial begin
      #(5ns * 150000);
      nfail++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      logic [31:0] v;
      logic [31:0] exp;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;

      // R12 reset state
      rd_reg(STAT, v); check("R12 status", v, 32'd0);
      for (int w = 0; w < 4; w++) begin
         rd_reg(3'(w), v); check("R12 config", v, 32'd0);
      end
      check("R12 irq", {31'd0, irq}, 32'd0);
      check("R12 dma_req", dreq, 32'd0);
      check("R12 trig", trig, 32'd0);

      // R9 readback
      wr_reg(3'd1, 32'hA5C3_1E0F);
      rd_reg(3'd1, v); check("R9 readback", v, 32'hA5C3_1E0F);
      wr_reg(3'd1, 32'd0);

      // Sweep every code over all pins
      for (int c = 0; c < 16; c++) begin
         for (int w = 0; w < 4; w++) wr_reg(3'(w), {8{4'(c)}});
         wait_cyc(3);
         wr_reg(STAT, 32'hFFFF_FFFF);
         exp = (c == 8) ? 32'hFFFF_FFFF : 32'd0;
         check_all($sformatf("code%0d idle R1 R6", c), c, exp, 32'd0);

         @(negedge clk); pins = EVN;
         wait_cyc(4);
         exp = (c == 8) ? 32'hFFFF_FFFF : (is_rise(c) || c == 12) ? EVN : 32'd0;
         check_all($sformatf("code%0d rise", c), c, exp, EVN);

         wr_reg(STAT, 32'd0);
         rd_reg(STAT, v); check($sformatf("code%0d R8 write zero", c), v, exp);

         wr_reg(STAT, 32'hFFFF_FFFF);
         exp = (c == 8) ? ~EVN : (c == 12) ? EVN : 32'd0;
         check_all($sformatf("code%0d R8 R6 clear", c), c, exp, EVN);

         @(negedge clk); pins = '0;
         wait_cyc(4);
         exp = (c == 8) ? 32'hFFFF_FFFF : (is_fall(c) || c == 12) ? EVN : 32'd0;
         check_all($sformatf("code%0d fall", c), c, exp, 32'd0);

         @(negedge clk); ddone = 32'h0000_FFFF;
         @(posedge clk);
         @(negedge clk); ddone = '0;
         #1;
         if (c >= 1 && c <= 3) exp = exp & 32'hFFFF_0000;
         check_all($sformatf("code%0d R3 dma done", c), c, exp, 32'd0);

         wr_reg(STAT, 32'hFFFF_FFFF);
         exp = (c == 8) ? 32'hFFFF_FFFF : 32'd0;
         check_all($sformatf("code%0d final clear", c), c, exp, 32'd0);
      end

      // R9 field position: pin 18 uses code 11, all others off
      for (int w = 0; w < 4; w++) wr_reg(3'(w), 32'd0);
      wr_reg(3'd2, 32'h0000_0B00);
      wr_reg(STAT, 32'hFFFF_FFFF);
      @(negedge clk); pins = 32'h0004_0000;
      wait_cyc(4);
      rd_reg(STAT, v); check("R9 pin18 mapping", v, 32'h0004_0000);
      check("R9 R5 irq", {31'd0, irq}, 32'd1);
      @(negedge clk); pins = '0;
      wait_cyc(4);
      wr_reg(STAT, 32'hFFFF_FFFF);

      // R10 latency on pin 0, code 9
      wr_reg(3'd2, 32'd0);
      wr_reg(3'd0, 32'h0000_0009);
      wr_reg(STAT, 32'hFFFF_FFFF);
      @(negedge clk); pins = 32'd1;
      @(posedge clk); @(negedge clk); #1;
      rd_reg(STAT, v); check("R10 after edge 1", v, 32'd0);
      @(posedge clk); @(negedge clk); #1;
      rd_reg(STAT, v); check("R10 after edge 2", v, 32'd0);
      @(posedge clk); @(negedge clk); #1;
      rd_reg(STAT, v); check("R10 after edge 3", v, 32'd1);

      // R11 clear lands in the capture cycle
      @(negedge clk); pins = '0;
      wait_cyc(4);
      wr_reg(STAT, 32'hFFFF_FFFF);
      rd_reg(STAT, v); check("R11 pre clear", v, 32'd0);
      @(negedge clk); pins = 32'd1;
      @(posedge clk); @(negedge clk);
      @(posedge clk);
      wr_reg(STAT, 32'd1);
      rd_reg(STAT, v); check("R11 set wins", v, 32'd1);
      wr_reg(STAT, 32'd1);
      rd_reg(STAT, v); check("R11 later clear", v, 32'd0);

      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

endmodule